// File: doc/BRIEF.md
# Stream Table Entry Address Generator

This block sits in the translation path of an I/O memory management unit. It takes a stream identifier and works out the byte address of that stream's entry in the stream table. Software programs the table base, the log2 of the table size, a split point and a format select. The format is either a flat array of 64-byte entries or a two-level arrangement. In the two-level arrangement, an 8-byte level-1 descriptor points at a level-2 array of entries.

Before the base is used, the block aligns it to the size of the table. It does this by clearing low address bits. How many bits are cleared depends on the format. In two-level mode there is a floor of five bits. When the alignment reaches the full address width, the base becomes zero. In two-level mode the block reads the level-1 descriptor over a request/ready read port and waits for the data. It then adds the level-2 offset to the pointer held in the descriptor. Results leave on a valid/ready output that carries the entry address and a fault flag.

Top module: `ste_addr_gen`

## Requirements
- R1: Only bits [AW-1:6] of `cfg_base` affect any address. Bits below 6 and bits at or above AW are ignored.
- R2: With `cfg_two_level`=0, the base is cleared below bit (log2size+5). `out_addr` is then that base plus sid×64, modulo 2^AW, with `out_fault`=0.
- R3: With `cfg_two_level`=1, the alignment shift is log2size−split+2, computed as a signed value. Any result below 5 is raised to 5, and negative results are included in this.
- R4: When the alignment shift is greater than or equal to AW, the aligned base is zero.
- R5: In two-level mode, `rd_addr` is the aligned base plus (sid >> split)×8. It is presented with `rd_valid` and has its low 3 bits zero.
- R6: For a descriptor whose span field is non-zero, `out_addr` is {desc[AW-1:6], 6'b0} plus (sid & (2^split−1))×64, with `out_fault`=0. The span field is desc[4:0].
- R7: A descriptor with span field desc[4:0]=0 gives `out_fault`=1 and `out_addr`=0.
- R8: `req_ready` is high only while the block is idle. A lookup is accepted when `req_valid` and `req_ready` are both high at a clock edge. The sid and all `cfg_*` inputs are sampled at that edge, so later changes to them have no effect on that lookup.
- R9: While `rd_valid`&&!`rd_ready`, `rd_addr` holds. While `out_valid`&&!`out_ready`, `out_addr` and `out_fault` hold. No result is lost or duplicated.
- R10: After reset, `req_ready`=1, `rd_valid`=0 and `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 64 | Programmed table base register |
| cfg_log2size | input | 6 | Log2 of table size |
| cfg_split | input | 5 | Two-level split point |
| cfg_two_level | input | 1 | 1 selects the two-level format |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle, lookup accepted |
| req_sid | input | SID_W | Stream identifier |
| rd_valid | output | 1 | Level-1 descriptor read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Level-1 descriptor address |
| rsp_valid | input | 1 | Descriptor data valid |
| rsp_data | input | 64 | Level-1 descriptor |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted |
| out_addr | output | AW | Stream table entry address |
| out_fault | output | 1 | Descriptor span fault |

## Verification
The bench targets several cases in which a wrong design would still produce plausible addresses. One is a two-level setup in which log2size−split+2 is negative. If that value were treated as unsigned, it would wrap to a huge shift and zero the base, instead of taking the floor of 5. Another is a shift of exactly AW. A comparison that is off by one would leave bit AW−1 set. A further case is a base register with junk in its low bits and in its upper 16 bits, which a design with a missing field mask would fold into the result. The bench also covers split values of zero and of at least the sid width, a zero span, and configuration inputs that are scrambled right after acceptance. Stalls on both handshakes are applied; a design that dropped or repeated a result under these stalls would leave the scoreboard out of step.

// File: rtl/ste_pkg.sv
package ste_pkg;

    localparam int CFG_W       = 64;
    localparam int LOG2_W      = 6;
    localparam int SPLIT_W     = 5;
    localparam int FIELD_LSB   = 6;
    localparam int DESC_SHIFT  = 3;
    localparam int ENTRY_SHIFT = 6;
    localparam int SHIFT_FLOOR = 5;
    localparam int SHIFT_W     = 9;
    localparam int SPAN_W      = 5;

    typedef logic signed [SHIFT_W-1:0] shift_t;

    typedef enum logic {
        FMT_LINEAR    = 1'b0,
        FMT_TWO_LEVEL = 1'b1
    } tbl_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_L1_REQ  = 2'd1,
        ST_L1_WAIT = 2'd2,
        ST_DONE    = 2'd3
    } walk_state_e;

    // Alignment shift for the table base, signed so that a negative
    // two-level result is floored rather than wrapped.
    function automatic shift_t align_shift(tbl_fmt_e fmt,
                                           logic [LOG2_W-1:0] lg,
                                           logic [SPLIT_W-1:0] sp);
        shift_t s;
        if (fmt == FMT_LINEAR) begin
            s = shift_t'({3'b000, lg}) + shift_t'(ENTRY_SHIFT - 1);
        end else begin
            s = shift_t'({3'b000, lg}) - shift_t'({4'b0000, sp}) + shift_t'(2);
            if (s < shift_t'(SHIFT_FLOOR)) begin
                s = shift_t'(SHIFT_FLOOR);
            end
        end
        return s;
    endfunction

    function automatic logic desc_span_zero(logic [CFG_W-1:0] d);
        return d[SPAN_W-1:0] == '0;
    endfunction

endpackage

// File: rtl/ste_base_align.sv
module ste_base_align
    import ste_pkg::*;
#(
    parameter int AW = 48
) (
    input  logic [AW-1:0] base_raw,
    input  shift_t        shift,
    output logic [AW-1:0] base_out
);

    logic zero_all;
    assign zero_all = (shift >= shift_t'(AW));

    logic unused_low;
    assign unused_low = ^base_raw[FIELD_LSB-1:0];

    for (genvar i = 0; i < AW; i++) begin : g_bit
        if (i < FIELD_LSB) begin : g_field_low
            assign base_out[i] = 1'b0;
        end else begin : g_field
            localparam shift_t IDX = shift_t'(i);
            assign base_out[i] = base_raw[i] & ~zero_all & (IDX >= shift);
        end
    end

endmodule

// File: rtl/ste_sid_index.sv
module ste_sid_index
    import ste_pkg::*;
#(
    parameter int AW    = 48,
    parameter int SID_W = 24
) (
    input  logic [SID_W-1:0]   sid,
    input  logic [SPLIT_W-1:0] split,
    output logic [AW-1:0]      l1_off,
    output logic [AW-1:0]      l2_off,
    output logic [AW-1:0]      lin_off
);

    localparam int PAD = AW - SID_W;

    logic [SID_W-1:0] l1_idx;
    logic [SID_W-1:0] l2_mask;
    logic [SID_W-1:0] l2_idx;

    assign l1_idx  = sid >> split;
    assign l2_mask = ~({SID_W{1'b1}} << split);
    assign l2_idx  = sid & l2_mask;

    assign l1_off  = {{PAD{1'b0}}, l1_idx} << DESC_SHIFT;
    assign l2_off  = {{PAD{1'b0}}, l2_idx} << ENTRY_SHIFT;
    assign lin_off = {{PAD{1'b0}}, sid}    << ENTRY_SHIFT;

endmodule

// File: rtl/ste_walk_ctrl.sv
module ste_walk_ctrl
    import ste_pkg::*;
#(
    parameter int AW = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  tbl_fmt_e         fmt,
    input  logic [AW-1:0]    base_aligned,
    input  logic [AW-1:0]    l1_off,
    input  logic [AW-1:0]    l2_off,
    input  logic [AW-1:0]    lin_off,
    output logic             req_ready,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [AW-1:0]    rd_addr,
    input  logic             rsp_valid,
    input  logic [CFG_W-1:0] rsp_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [AW-1:0]    out_addr,
    output logic             out_fault
);

    walk_state_e   state_q;
    logic [AW-1:0] l1_addr_q;
    logic [AW-1:0] l2_off_q;
    logic [AW-1:0] out_addr_q;
    logic          fault_q;
    logic [AW-1:0] l2_ptr;

    assign l2_ptr = {rsp_data[AW-1:FIELD_LSB], {FIELD_LSB{1'b0}}};

    logic unused_desc;
    assign unused_desc = ^{rsp_data[CFG_W-1:AW], rsp_data[FIELD_LSB-1:SPAN_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            l1_addr_q  <= '0;
            l2_off_q   <= '0;
            out_addr_q <= '0;
            fault_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        l1_addr_q <= base_aligned + l1_off;
                        l2_off_q  <= l2_off;
                        if (fmt == FMT_LINEAR) begin
                            out_addr_q <= base_aligned + lin_off;
                            fault_q    <= 1'b0;
                            state_q    <= ST_DONE;
                        end else begin
                            state_q    <= ST_L1_REQ;
                        end
                    end
                end
                ST_L1_REQ: begin
                    if (rd_ready) state_q <= ST_L1_WAIT;
                end
                ST_L1_WAIT: begin
                    if (rsp_valid) begin
                        if (desc_span_zero(rsp_data)) begin
                            out_addr_q <= '0;
                            fault_q    <= 1'b1;
                        end else begin
                            out_addr_q <= l2_ptr + l2_off_q;
                            fault_q    <= 1'b0;
                        end
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (out_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rd_valid  = (state_q == ST_L1_REQ);
    assign rd_addr   = l1_addr_q;
    assign out_valid = (state_q == ST_DONE);
    assign out_addr  = out_addr_q;
    assign out_fault = fault_q;

endmodule

// File: rtl/ste_addr_gen.sv
module ste_addr_gen
    import ste_pkg::*;
#(
    parameter int AW    = 48,
    parameter int SID_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [63:0]      cfg_base,
    input  logic [5:0]       cfg_log2size,
    input  logic [4:0]       cfg_split,
    input  logic             cfg_two_level,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SID_W-1:0] req_sid,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [AW-1:0]    rd_addr,
    input  logic             rsp_valid,
    input  logic [63:0]      rsp_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [AW-1:0]    out_addr,
    output logic             out_fault
);

    if (AW > CFG_W || AW < SID_W + ENTRY_SHIFT + 1) begin : g_bad_param
        $error("ste_addr_gen: AW out of range for SID_W");
    end

    tbl_fmt_e      fmt;
    shift_t        shift;
    logic [AW-1:0] base_aligned;
    logic [AW-1:0] l1_off;
    logic [AW-1:0] l2_off;
    logic [AW-1:0] lin_off;

    assign fmt   = tbl_fmt_e'(cfg_two_level);
    assign shift = align_shift(fmt, cfg_log2size, cfg_split);

    logic unused_cfg_hi;
    if (AW < CFG_W) begin : g_hi
        assign unused_cfg_hi = ^cfg_base[CFG_W-1:AW];
    end else begin : g_no_hi
        assign unused_cfg_hi = 1'b0;
    end

    ste_base_align #(.AW(AW)) u_align (
        .base_raw (cfg_base[AW-1:0]),
        .shift    (shift),
        .base_out (base_aligned)
    );

    ste_sid_index #(.AW(AW), .SID_W(SID_W)) u_index (
        .sid     (req_sid),
        .split   (cfg_split),
        .l1_off  (l1_off),
        .l2_off  (l2_off),
        .lin_off (lin_off)
    );

    ste_walk_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .fmt          (fmt),
        .base_aligned (base_aligned),
        .l1_off       (l1_off),
        .l2_off       (l2_off),
        .lin_off      (lin_off),
        .req_ready    (req_ready),
        .rd_valid     (rd_valid),
        .rd_ready     (rd_ready),
        .rd_addr      (rd_addr),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_addr     (out_addr),
        .out_fault    (out_fault)
    );

endmodule

// File: rtl/ste_addr_gen_chk.sv
module ste_addr_gen_chk #(
    parameter int AW = 48
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [AW-1:0] rd_addr,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_addr,
    input logic          out_fault
);

    // R8
    single_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_ready, rd_valid, out_valid}));

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R5
    desc_align_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_addr[2:0] == 3'b000);

    // R6
    entry_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_fault |-> out_addr[5:0] == 6'd0);

    // R7
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_fault |-> out_addr == '0);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_fault));

endmodule

bind ste_addr_gen ste_addr_gen_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_fault (out_fault)
);

// File: tb/sim_ste_addr_gen.sv
module sim_ste_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 48;
    localparam int SID_W = 24;
    localparam longint unsigned AMASK = (64'd1 << AW) - 64'd1;

    typedef struct {
        longint unsigned addr;
        bit              fault;
        string           tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [63:0]      cfg_base = '0;
    logic [5:0]       cfg_log2size = '0;
    logic [4:0]       cfg_split = '0;
    logic             cfg_two_level = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [SID_W-1:0] req_sid = '0;
    logic             rd_valid;
    logic             rd_ready = 1'b0;
    logic [AW-1:0]    rd_addr;
    logic             rsp_valid = 1'b0;
    logic [63:0]      rsp_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [AW-1:0]    out_addr;
    logic             out_fault;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ste_addr_gen #(.AW(AW), .SID_W(SID_W)) u0 (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_log2size(cfg_log2size),
        .cfg_split(cfg_split), .cfg_two_level(cfg_two_level),
        .req_valid(req_valid), .req_ready(req_ready), .req_sid(req_sid),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_fault(out_fault)
    );

    task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Reference from the requirements
    function automatic longint unsigned ref_base(longint unsigned base, int lg, int sp, bit two);
        int sh;
        longint unsigned b;
        sh = two ? (lg - sp + 2) : (lg + 5);
        if (two && sh < 5) sh = 5;
        b = base & AMASK & ~64'h3F;
        if (sh >= AW) return 64'd0;
        return b & ~((64'd1 << sh) - 64'd1);
    endfunction

    task automatic lookup(string tag, longint unsigned base, int lg, int sp, bit two,
                          longint unsigned sid, longint unsigned desc);
        longint unsigned b, l1, fin, l2mask;
        bit flt;
        exp_t e;
        b      = ref_base(base, lg, sp, two);
        l2mask = (sp >= 64) ? ~64'd0 : ((64'd1 << sp) - 64'd1);
        l1     = (b + ((sid >> sp) << 3)) & AMASK;
        flt    = 1'b0;
        if (!two) fin = (b + (sid << 6)) & AMASK;
        else if (desc[4:0] == 5'd0) begin fin = 0; flt = 1'b1; end
        else fin = ((desc & AMASK & ~64'h3F) + ((sid & l2mask) << 6)) & AMASK;
        e.addr = fin; e.fault = flt; e.tag = tag;
        exp_q.push_back(e);

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_base = base; cfg_log2size = 6'(lg); cfg_split = 5'(sp);
        cfg_two_level = two; req_sid = SID_W'(sid); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R8: busy after accept; scramble config to show it was sampled
        check(req_ready == 1'b0, "R8 busy", req_ready, 0);
        cfg_base = 64'hDEAD_BEEF_CAFE_F00D; cfg_log2size = 6'd17;
        cfg_split = 5'd3; cfg_two_level = ~two; req_sid = '1;
        if (two) begin
            while (!rd_valid) @(negedge clk);
            check(rd_addr == AW'(l1), {"R5 ", tag}, rd_addr, l1);
            repeat (2) @(negedge clk);
            check(rd_valid && rd_addr == AW'(l1), {"R9 rd hold ", tag}, rd_addr, l1);
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
            @(negedge clk);
            rsp_valid = 1'b1; rsp_data = desc;
            @(negedge clk);
            rsp_valid = 1'b0; rsp_data = '1;
        end
    endtask

    // Scoreboard monitor
    initial begin
        int cyc = 0;
        bit hold = 1'b0;
        longint unsigned held_addr = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst) continue;
            cyc++;
            out_ready = (cyc % 3) != 0;
            if (hold) begin
                check(out_valid && out_addr == AW'(held_addr), "R9 out hold", out_addr, held_addr);
                hold = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 spurious result", out_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(out_addr == AW'(e.addr), {"addr ", e.tag}, out_addr, e.addr);
                    check(out_fault == e.fault, {"fault ", e.tag}, out_fault, e.fault);
                end
            end else if (out_valid) begin
                hold = 1'b1;
                held_addr = out_addr;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10
        check(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
        check(rd_valid == 1'b0 && out_valid == 1'b0, "R10 idle outputs",
              {rd_valid, out_valid}, 0);
        rst = 1'b0;

        // R1, R2: junk in low and top bits of base; shift 9
        lookup("R1 R2 linear junk", 64'hFFFF_1234_5678_9ABF, 4, 0, 1'b0, 64'h15, 0);
        lookup("R2 linear lg10", 64'h0000_0000_00AB_CDC0, 10, 0, 1'b0, 64'h5, 0);
        // R4: shift exactly AW
        lookup("R4 linear shift48", 64'h0000_FFFF_FFFF_FFC0, 43, 0, 1'b0, 64'h3, 0);
        // R2: shift 47 keeps bit 47 only
        lookup("R2 linear shift47", 64'h0000_FFFF_FFFF_FFC0, 42, 0, 1'b0, 64'h3, 0);
        // R3 R5 R6: shift 10
        lookup("R6 two-level", 64'h0000_0012_3456_7FC0, 16, 8, 1'b1, 64'h1234,
               64'h0000_ABCD_1234_5681);
        // R3: negative shift floored to 5
        lookup("R3 negative shift", 64'h0000_0000_0001_2340, 2, 10, 1'b1, 64'h5A3,
               64'hFFFF_1234_5678_9AC3);
        // R4: two-level shift 65
        lookup("R4 two-level zero", 64'h0000_7777_8888_99C0, 63, 0, 1'b1, 64'h2A,
               64'h0000_0000_1000_0001);
        // R7: span zero
        lookup("R7 span fault", 64'h0000_0000_0010_0000, 12, 4, 1'b1, 64'h77,
               64'h0000_1111_2222_3340);
        // split at or beyond sid width
        lookup("R6 split24", 64'h0000_0000_4000_0000, 30, 24, 1'b1, 64'hABCDEF,
               64'h0000_0000_8000_0002);
        lookup("R2 linear after fault", 64'h0000_0000_0000_0000, 20, 0, 1'b0, 64'hFFFFFF, 0);

        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        check(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 0);
        finish_run();
    end

endmodule